// File: doc/BRIEF.md
# Port-Write Receive Controller

This block takes incoming maintenance port-write payloads and stores them in a single receive slot. The link layer has already parsed each payload and presents it as a stream of valid-qualified 32-bit words. The last word is marked, and a separate marker flags a corrupted transfer. A good payload is exactly sixteen words, or 64 bytes. The block writes it through a plain memory write port into consecutive word addresses, starting at a programmable base address. It then reports the slot as occupied and can raise an interrupt.

Software programs three registers: control, status and base address. While the slot is occupied, any further payload is thrown away and flagged. Software reads the stored payload from memory, then frees the slot with a self-clearing release command in the control register. A malformed payload raises a sticky error flag instead of filling the slot. That flag can only be acknowledged after the unit has been switched off.

Top module: `pw_rx_top`

## Requirements
- R1: After reset, the control, status and base registers read 0, the interrupt is low and no memory write occurs.
- R2: An accepted payload's word i (counting from 0) is written with its data to base + 4*i, one write per word. Only the first sixteen words are ever written.
- R3: A payload that ends after exactly sixteen words with no error marker sets slot-full (status bit 20) and the full-interrupt flag (status bit 4). The interrupt output is high while bit 4 is set and full-interrupt enable (control bit 8) is 1.
- R4: A payload that starts while slot-full is set and the unit is enabled is not written to memory. It sets the discarded flag (status bit 3) and leaves slot-full set.
- R5: Writing control with bit 1 set clears slot-full so that the next payload is accepted. Bit 1 always reads back as 0.
- R6: Status bits 4 and 3 clear when 1 is written to them. Writing 0 leaves them unchanged, and slot-full cannot be written through the status register.
- R7: A payload that carries an error marker on any word, or that ends with a word count other than sixteen, sets the error flag (status bit 7) and not slot-full. The interrupt is high while bit 7 is set and error-interrupt enable (control bit 5) is 1.
- R8: Writing 1 to status bit 7 clears it only while enable (control bit 0) is 0.
- R9: A payload that starts while enable is 0 is ignored completely: no memory write and no status change.
- R10: Status bit 2 (busy) reads 1 while a payload is being accepted.
- R11: The control register keeps only bits 20, 8, 5 and 0. All other bits read 0.
- R12: The base register (address 2) takes a write only while enable is 0 and no payload is being accepted. Register addresses: 0 control, 1 status, 2 base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 control, 1 status, 2 base |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational on regAddr) |
| pwValid | input | 1 | Payload word valid |
| pwData | input | DATA_W | Payload word |
| pwLast | input | 1 | Final word of the payload |
| pwErr | input | 1 | Error marker on this word |
| memWrEn | output | 1 | Slot memory write enable |
| memWrAddr | output | ADDR_W | Slot memory byte address |
| memWrData | output | DATA_W | Slot memory write data |
| irq | output | 1 | Interrupt request |

## Verification
Register writes and status updates take effect at the clock edge that samples them. The bench therefore reads registers at the falling edge straight after a write or after the final payload word, with no extra wait. The interrupt is decoded from the status flags, so it is checked in that same falling-edge window. Memory writes are registered and lag their payload word by one cycle. The bench records them on its own rising-edge monitor and inspects the record one full cycle after the last word, so the final write is always included. Payload lengths 1 to 18 are each run with and without an error marker, and the expected flags are computed directly from the length and the marker.

// File: rtl/pw_rx_pkg.sv
package pw_rx_pkg;
  localparam int REG_W = 32;

  // control register bit positions
  localparam int CTL_SNOOP = 20;
  localparam int CTL_FULLIE = 8;
  localparam int CTL_ERRIE = 5;
  localparam int CTL_RELEASE = 1;
  localparam int CTL_EN = 0;
  localparam logic [REG_W-1:0] CTL_KEEP =
    (REG_W'(1) << CTL_SNOOP) | (REG_W'(1) << CTL_FULLIE) |
    (REG_W'(1) << CTL_ERRIE) | (REG_W'(1) << CTL_EN);

  // status register bit positions
  localparam int STS_FULL = 20;
  localparam int STS_ERR = 7;
  localparam int STS_FULLINT = 4;
  localparam int STS_DROP = 3;
  localparam int STS_BUSY = 2;

  localparam logic [1:0] ADR_CTL = 2'd0;
  localparam logic [1:0] ADR_STS = 2'd1;
  localparam logic [1:0] ADR_BASE = 2'd2;

  typedef enum logic [1:0] {RX_IDLE, RX_TAKE, RX_SKIP} rxState_e;

  typedef struct packed {
    logic firstWord;
    logic nextWord;
    logic baseLoad;
  } dpStrobe_t;
endpackage

// File: rtl/pw_rx_datapath.sv
module pw_rx_datapath
  import pw_rx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int WORDS = 16,
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [DATA_W-1:0] wordIn,
  output logic [ADDR_W-1:0] baseAddr,
  output logic [CNT_W-1:0]  wordCnt,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData
);
  localparam int SHIFT = $clog2(DATA_W / 8);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(WORDS * (DATA_W / 8));

  logic [CNT_W-1:0] idx;
  logic take;

  assign take = strb.firstWord | strb.nextWord;
  assign idx = strb.firstWord ? '0 : wordCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      wordCnt <= '0;
      memWrEn <= 1'b0;
      memWrAddr <= '0;
      memWrData <= '0;
    end else begin
      memWrEn <= take && (idx < CNT_W'(WORDS));
      if (take) begin
        wordCnt <= (idx == CNT_W'(WORDS)) ? idx : idx + 1'b1;
        memWrAddr <= baseAddr + (ADDR_W'(idx) << SHIFT);
        memWrData <= wordIn;
      end
      if (strb.baseLoad) baseAddr <= baseIn;
    end
  end

  // R2: every slot write lands inside the 16-word window above base
  a_r2_addr_in_slot: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> ((memWrAddr - baseAddr) < SPAN));
endmodule

// File: rtl/pw_rx_control.sv
module pw_rx_control
  import pw_rx_pkg::*;
#(
  parameter int WORDS = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic             pwValid,
  input  logic             pwLast,
  input  logic             pwErr,
  input  logic [CNT_W-1:0] wordCnt,
  output dpStrobe_t        strb,
  output logic [REG_W-1:0] ctlReg,
  output logic [REG_W-1:0] stsReg,
  output logic             irq,
  output logic             enabled,
  output logic             idle,
  output logic             slotFull
);
  rxState_e state, stateNxt;
  logic errSeen, errFlag, fullInt, dropFlag;
  logic ctlWr, stsWr, startTake, startSkip, dropNow, wordIn, wordEnd;
  logic errNow, goodEnd, badEnd, countOk;

  assign ctlWr = regWrEn && (regAddr == ADR_CTL);
  assign stsWr = regWrEn && (regAddr == ADR_STS);
  assign enabled = ctlReg[CTL_EN];
  assign idle = (state == RX_IDLE);

  assign startTake = idle && pwValid && enabled && !slotFull;
  assign startSkip = idle && pwValid && !(enabled && !slotFull);
  assign dropNow = idle && pwValid && enabled && slotFull;
  assign wordIn = startTake || ((state == RX_TAKE) && pwValid);
  assign wordEnd = wordIn && pwLast;
  assign errNow = errSeen || pwErr;
  assign countOk = startTake ? (WORDS == 1) : (wordCnt == CNT_W'(WORDS - 1));
  assign goodEnd = wordEnd && !errNow && countOk;
  assign badEnd = wordEnd && !goodEnd;

  assign strb.firstWord = startTake;
  assign strb.nextWord = (state == RX_TAKE) && pwValid;
  assign strb.baseLoad = regWrEn && (regAddr == ADR_BASE) && !enabled && idle;

  always_comb begin
    stateNxt = state;
    unique case (state)
      RX_IDLE: begin
        if (startTake && !pwLast) stateNxt = RX_TAKE;
        else if (startSkip && !pwLast) stateNxt = RX_SKIP;
      end
      RX_TAKE: if (wordEnd) stateNxt = RX_IDLE;
      RX_SKIP: if (pwValid && pwLast) stateNxt = RX_IDLE;
      default: stateNxt = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= RX_IDLE;
      ctlReg <= '0;
      errSeen <= 1'b0;
      slotFull <= 1'b0;
      fullInt <= 1'b0;
      dropFlag <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      state <= stateNxt;
      if (ctlWr) ctlReg <= regWrData & CTL_KEEP;
      if (wordEnd) errSeen <= 1'b0;
      else if (wordIn) errSeen <= errNow;

      if (goodEnd) slotFull <= 1'b1;
      else if (ctlWr && regWrData[CTL_RELEASE]) slotFull <= 1'b0;

      if (goodEnd) fullInt <= 1'b1;
      else if (stsWr && regWrData[STS_FULLINT]) fullInt <= 1'b0;

      if (dropNow) dropFlag <= 1'b1;
      else if (stsWr && regWrData[STS_DROP]) dropFlag <= 1'b0;

      if (badEnd) errFlag <= 1'b1;
      else if (stsWr && regWrData[STS_ERR] && !enabled) errFlag <= 1'b0;
    end
  end

  always_comb begin
    stsReg = '0;
    stsReg[STS_FULL] = slotFull;
    stsReg[STS_ERR] = errFlag;
    stsReg[STS_FULLINT] = fullInt;
    stsReg[STS_DROP] = dropFlag;
    stsReg[STS_BUSY] = (state == RX_TAKE);
  end

  assign irq = (fullInt && ctlReg[CTL_FULLIE]) || (errFlag && ctlReg[CTL_ERRIE]);

  // R8: error flag survives any cycle in which the unit is enabled
  a_r8_err_kept_enabled: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && enabled) |=> errFlag);
  // R3: slot-full never rises without the full-interrupt flag
  a_r3_full_with_int: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slotFull) |-> fullInt);
  // R4: a payload arriving at a full slot leaves it full
  a_r4_drop_keeps_full: assert property (@(posedge clk) disable iff (!rstN)
    (idle && pwValid && slotFull && !ctlWr) |=> slotFull);
endmodule

// File: rtl/pw_rx_top.sv
module pw_rx_top
  import pw_rx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int WORDS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              pwValid,
  input  logic [DATA_W-1:0] pwData,
  input  logic              pwLast,
  input  logic              pwErr,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              irq
);
  localparam int CNT_W = $clog2(WORDS + 1);

  dpStrobe_t strb;
  logic [CNT_W-1:0] wordCnt;
  logic [ADDR_W-1:0] baseAddr;
  logic [REG_W-1:0] ctlReg, stsReg;
  logic enabled, idle, slotFull;

  pw_rx_control #(.WORDS(WORDS), .CNT_W(CNT_W)) ctl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .pwValid(pwValid), .pwLast(pwLast), .pwErr(pwErr),
    .wordCnt(wordCnt), .strb(strb), .ctlReg(ctlReg), .stsReg(stsReg),
    .irq(irq), .enabled(enabled), .idle(idle), .slotFull(slotFull)
  );

  pw_rx_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS(WORDS), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .baseIn(regWrData[ADDR_W-1:0]),
    .wordIn(pwData), .baseAddr(baseAddr), .wordCnt(wordCnt),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

  always_comb begin
    unique case (regAddr)
      ADR_CTL:  regRdData = ctlReg;
      ADR_STS:  regRdData = stsReg;
      ADR_BASE: regRdData = REG_W'(baseAddr);
      default:  regRdData = '0;
    endcase
  end

  // R9: an idle, disabled unit produces no slot write next cycle
  a_r9_off_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (!enabled && idle) |=> !memWrEn);
  // R4: a payload arriving at a full slot is never written
  a_r4_full_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (idle && slotFull && pwValid) |=> !memWrEn);
endmodule

// File: tb/pw_rx_top_tb_top.sv
`timescale 1ns/1ps
module pw_rx_top_tb_top;
  localparam logic [31:0] C_EN = 32'h1, C_EIE = 32'h20, C_FIE = 32'h100,
                          C_SNP = 32'h0010_0000, C_REL = 32'h2;
  localparam logic [31:0] S_FULL = 32'h0010_0000, S_ERR = 32'h80, S_FINT = 32'h10,
                          S_DROP = 32'h8, S_BUSY = 32'h4;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [31:0] regWrData = '0, regRdData;
  logic pwValid = 1'b0, pwLast = 1'b0, pwErr = 1'b0;
  logic [31:0] pwData = '0;
  logic memWrEn, irq;
  logic [31:0] memWrAddr, memWrData;

  int total = 0, bad = 0;
  int wrCount = 0;
  logic [31:0] wrAddr [0:63];
  logic [31:0] wrData [0:63];
  logic [31:0] tbBase = 32'h0000_1000;

  always #4 clk = ~clk;

  pw_rx_top dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pwValid(pwValid),
    .pwData(pwData), .pwLast(pwLast), .pwErr(pwErr), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .irq(irq)
  );

  always @(posedge clk) begin
    if (memWrEn && wrCount < 64) begin
      wrAddr[wrCount] = memWrAddr;
      wrData[wrCount] = memWrData;
      wrCount = wrCount + 1;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  function automatic logic [31:0] wordVal(logic [31:0] seed, int i);
    return seed + 32'(i) * 32'h0101_0101;
  endfunction

  // word i driven after a falling edge; returns at the falling edge after the last word's edge
  task automatic sendPkt(int n, int errAt, logic [31:0] seed, bit chkBusy);
    logic [31:0] r;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (chkBusy && i == 3) begin
        regRead(2'd1, r);
        check("R10 busy during capture", r & S_BUSY, S_BUSY);
      end
      pwValid = 1'b1; pwData = wordVal(seed, i);
      pwLast = (i == n - 1); pwErr = (i == errAt);
    end
    @(negedge clk);
    pwValid = 1'b0; pwLast = 1'b0; pwErr = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    regRead(2'd0, r); check("R1 control after reset", r, 0);
    regRead(2'd1, r); check("R1 status after reset", r, 0);
    regRead(2'd2, r); check("R1 base after reset", r, 0);
    check("R1 irq after reset", {31'd0, irq}, 0);
    check("R1 no writes after reset", wrCount, 0);

    // R12 base load while disabled, R11 control mask
    regWrite(2'd2, tbBase);
    regRead(2'd2, r); check("R12 base load disabled", r, tbBase);
    regWrite(2'd0, 32'hFFFF_FFFD);
    regRead(2'd0, r); check("R11 control mask", r, C_SNP | C_FIE | C_EIE | C_EN);
    regWrite(2'd2, 32'h0000_8000);
    regRead(2'd2, r); check("R12 base ignored while enabled", r, tbBase);

    // R2 R3 first capture
    regWrite(2'd0, C_SNP | C_FIE | C_EIE | C_EN);
    wrCount = 0;
    sendPkt(16, -1, 32'hA000_0000, 1'b1);
    regRead(2'd1, r); check("R3 full and int after capture", r, S_FULL | S_FINT);
    check("R3 irq with full enable", {31'd0, irq}, 1);
    tick();
    check("R2 write count", wrCount, 16);
    for (int i = 0; i < 16; i++) begin
      check("R2 word address", wrAddr[i], tbBase + 32'(4 * i));
      check("R2 word data", wrData[i], wordVal(32'hA000_0000, i));
    end

    // R4 second payload dropped
    wrCount = 0;
    sendPkt(16, -1, 32'hB000_0000, 1'b0);
    tick();
    check("R4 no write while full", wrCount, 0);
    regRead(2'd1, r); check("R4 drop flagged, still full", r, S_FULL | S_FINT | S_DROP);

    // R6 write-one-to-clear
    regWrite(2'd1, 32'h0);
    regRead(2'd1, r); check("R6 zero write no effect", r, S_FULL | S_FINT | S_DROP);
    regWrite(2'd1, S_FINT | S_DROP | S_FULL);
    regRead(2'd1, r); check("R6 flags cleared, full kept", r, S_FULL);
    check("R6 irq low after clear", {31'd0, irq}, 0);

    // R5 release then accept again
    regWrite(2'd0, C_SNP | C_FIE | C_EIE | C_EN | C_REL);
    regRead(2'd1, r); check("R5 release clears full", r, 0);
    regRead(2'd0, r); check("R5 release bit reads 0", r, C_SNP | C_FIE | C_EIE | C_EN);
    wrCount = 0;
    sendPkt(16, -1, 32'hC000_0000, 1'b0);
    tick();
    check("R5 accepted after release", wrCount, 16);
    check("R5 new data stored", wrData[15], wordVal(32'hC000_0000, 15));

    // R3 interrupt enable sweep
    for (int fie = 0; fie < 2; fie++) begin
      regWrite(2'd0, C_EN | C_REL | (fie != 0 ? C_FIE : 32'h0));
      regWrite(2'd1, S_FINT | S_DROP);
      sendPkt(16, -1, 32'h0000_0100 * 32'(fie), 1'b0);
      check("R3 irq follows full enable", {31'd0, irq}, 32'(fie));
    end
    regWrite(2'd0, C_EN | C_REL);
    regWrite(2'd1, S_FINT);

    // R7 R8 length and error sweep
    for (int n = 1; n <= 18; n++) begin
      for (int e = 0; e < 2; e++) begin
        bit good;
        good = (n == 16) && (e == 0);
        regWrite(2'd0, C_EN | C_EIE);
        wrCount = 0;
        sendPkt(n, (e != 0) ? n / 2 : -1, 32'h1000_0000 * 32'(n), 1'b0);
        regRead(2'd1, r);
        check("R7 status after payload", r, good ? (S_FULL | S_FINT) : S_ERR);
        check("R7 irq from error enable", {31'd0, irq}, good ? 0 : 1);
        tick();
        check("R2 writes capped", wrCount, (n < 16) ? n : 16);
        if (good) begin
          regWrite(2'd0, C_EN | C_EIE | C_REL);
          regWrite(2'd1, S_FINT);
        end else begin
          regWrite(2'd1, S_ERR);
          regRead(2'd1, r); check("R8 error held while enabled", r, S_ERR);
          regWrite(2'd0, 32'h0);
          regWrite(2'd1, S_ERR);
          regRead(2'd1, r); check("R8 error cleared while disabled", r, 0);
        end
      end
    end

    // R9 disabled: ignored
    regWrite(2'd0, C_FIE | C_EIE);
    wrCount = 0;
    sendPkt(16, -1, 32'hD000_0000, 1'b0);
    tick();
    check("R9 no write while disabled", wrCount, 0);
    regRead(2'd1, r); check("R9 status untouched", r, 0);
    check("R9 irq low", {31'd0, irq}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule